// File: doc/BRIEF.md
# Parallel Pixel-Array Line Rasterizer

This block is a small frame buffer in which every pixel has its own storage cell, and which draws a straight segment in a single array write. The grid has one calculation unit beside every column and one beside every row. When a draw command is accepted, these units work out shared values for the segment. Each cell then compares the value from its row unit with the value from its column unit. Every cell where the two match stores the segment colour on the same clock edge. The time this takes does not depend on the length or the slope of the segment.

Along the major axis (the axis with the larger extent), each unit inside the segment's span computes the rounded coordinate of the line on the other axis. Units on the other axis simply present their own index. So in each step along the major axis, exactly one cell sees a match.

Besides the draw port, the block gives:
- random single-pixel read and write access;
- a raster port that streams the stored pixels in row-major order, with a start-of-frame flag on pixel (0,0).

The grid width and height must be powers of two.

Top module: `pixel_grid_rasterizer`

## Requirements
- R1: After reset:
  - every pixel holds 0;
  - `draw_ready` is 1;
  - `scan_valid` and `scan_sof` are 0;
  - `acc_rdata` is 0.
- R2: A draw is accepted on a clock edge where `draw_valid` and `draw_ready` are both 1. `draw_ready` is 0 for the one cycle after acceptance and then returns to 1. The selected pixels change on the clock edge that follows the acceptance edge. A command held valid while `draw_ready` is 0 is not taken until `draw_ready` returns to 1.
- R3: A segment with |x1-x0| >= |y1-y0| is x-major.
  - The start point is the endpoint with the smaller x; when both x values are equal, the start point is (x0,y0).
  - For each column x from the start x to the end x, with k = x - start x, exactly one pixel is written.
  - Its row is y_start ± floor((2·|dy|·k + |dx|) / (2·|dx|)), where the sign is the direction from y_start to the other endpoint's y. This is round-half-up of the exact quotient.
- R4: A segment with |y1-y0| > |x1-x0| is y-major. It follows the R3 rule with the axes swapped:
  - the start point is the endpoint with the smaller y;
  - one pixel is written per row, in the column given by the rounded x.
- R5: Swapping the two endpoints of a segment writes exactly the same set of pixels.
- R6: A segment whose two endpoints are equal writes exactly one pixel.
- R7: A draw leaves every pixel outside its computed set unchanged.
- R8: Random access uses `acc_x` and `acc_y`.
  - With `acc_en`=1 and `acc_we`=1, `acc_wdata` is stored at that pixel on the clock edge.
  - With `acc_en`=1 and `acc_we`=0, `acc_rdata` shows that pixel's value as it was before the edge, from the edge onward.
  - `acc_rdata` holds its value in every other cycle.
- R9: If a draw write and a random write hit the same pixel on the same edge, the draw colour is stored.
- R10: In each cycle with `scan_en`=1:
  - on the edge, `scan_valid` becomes 1 and `scan_data` takes the pixel at the scan pointer;
  - the pointer then advances with x fastest, and wraps from the last pixel back to (0,0);
  - `scan_sof` is 1 exactly when that pixel is (0,0).
  
  With `scan_en`=0, `scan_valid` drops to 0 and the pointer holds.
- R11: The scan returns a pixel's contents as they stand before that edge's writes. A draw or random write that happens during a scan therefore shows at the next scan visit to that pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| draw_valid | input | 1 | Draw command present |
| draw_ready | output | 1 | Draw command can be taken |
| draw_x0 | input | log2(COLS) | First endpoint column |
| draw_y0 | input | log2(ROWS) | First endpoint row |
| draw_x1 | input | log2(COLS) | Second endpoint column |
| draw_y1 | input | log2(ROWS) | Second endpoint row |
| draw_color | input | PIX_W | Colour written along the segment |
| acc_en | input | 1 | Random access enable |
| acc_we | input | 1 | Random access is a write |
| acc_x | input | log2(COLS) | Random access column |
| acc_y | input | log2(ROWS) | Random access row |
| acc_wdata | input | PIX_W | Random write value |
| acc_rdata | output | PIX_W | Random read value |
| scan_en | input | 1 | Advance the raster scan |
| scan_valid | output | 1 | Raster pixel valid |
| scan_sof | output | 1 | Raster pixel is (0,0) |
| scan_data | output | PIX_W | Raster pixel value |

## Verification
The bench builds the block at 16 columns by 16 rows with 8-bit pixels. At that size a full-frame scan takes 256 cycles, so the whole array can be read back after every draw. The coordinate range is still large enough to reach all eight octants, shallow and steep slopes with rounding ties, and both endpoint orders. The 4-bit coordinates also reach the grid edges at 0 and 15, where a wrong rounding step or span end would write outside the segment.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

    // Which axis a segment advances along one pixel per step.
    typedef enum logic {
        MAJOR_X = 1'b0,
        MAJOR_Y = 1'b1
    } major_e;

endpackage

// File: rtl/pgr_axis_unit.sv
// One calculation unit for a row or a column. On the major axis it produces
// the rounded minor coordinate of the segment at its own index; on the minor
// axis it presents its own index as the compare key.
module pgr_axis_unit #(
    parameter int KW  = 4,
    parameter int IDX = 0
) (
    input  logic          is_major,
    input  logic [KW-1:0] s_major,
    input  logic [KW-1:0] s_minor,
    input  logic [KW-1:0] dmaj,
    input  logic [KW-1:0] dmin,
    input  logic          minor_neg,
    output logic [KW-1:0] key,
    output logic          act
);
    localparam int PW = 2 * KW + 2;

    logic [KW:0]   idx_w;
    logic [KW:0]   lo_w;
    logic [KW:0]   hi_w;
    logic [KW-1:0] step;
    logic [PW-1:0] num;
    logic [PW-1:0] den;
    logic [PW-1:0] quo;

    always_comb begin
        idx_w = (KW+1)'(IDX);
        lo_w  = {1'b0, s_major};
        hi_w  = lo_w + {1'b0, dmaj};
        step  = KW'(idx_w - lo_w);
        // round half up: (2*dmin*step + dmaj) / (2*dmaj)
        num   = ((PW'(dmin) * PW'(step)) << 1) + PW'(dmaj);
        den   = PW'(dmaj) << 1;
        quo   = (dmaj == '0) ? '0 : (num / den);
        if (is_major) begin
            act = (idx_w >= lo_w) && (idx_w <= hi_w);
            key = minor_neg ? (s_minor - KW'(quo)) : (s_minor + KW'(quo));
        end else begin
            act = 1'b1;
            key = KW'(IDX);
        end
    end
endmodule

// File: rtl/pgr_cell.sv
// One pixel of storage. A draw hit overrides a random write on the same edge.
module pgr_cell #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             draw_hit,
    input  logic [PIX_W-1:0] draw_color,
    input  logic             poke_hit,
    input  logic [PIX_W-1:0] poke_data,
    output logic [PIX_W-1:0] value
);
    logic [PIX_W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (poke_hit) val_d = poke_data;
        if (draw_hit) val_d = draw_color;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign value = val_q;
endmodule

// File: rtl/pgr_scan.sv
// Row-major raster pointer with registered pixel output.
module pgr_scan #(
    parameter int COLS  = 16,
    parameter int ROWS  = 16,
    parameter int PIX_W = 8,
    localparam int XW   = $clog2(COLS),
    localparam int YW   = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PIX_W-1:0] pix_in,
    output logic [XW-1:0]    ptr_x,
    output logic [YW-1:0]    ptr_y,
    output logic             out_valid,
    output logic             out_sof,
    output logic [PIX_W-1:0] out_data
);
    typedef struct packed {
        logic [XW-1:0]    x;
        logic [YW-1:0]    y;
        logic             valid;
        logic             sof;
        logic [PIX_W-1:0] data;
    } scan_t;

    scan_t sc_d, sc_q;

    always_comb begin
        sc_d       = sc_q;
        sc_d.valid = en;
        sc_d.sof   = en && (sc_q.x == '0) && (sc_q.y == '0);
        if (en) begin
            sc_d.data = pix_in;
            if (sc_q.x == XW'(COLS - 1)) begin
                sc_d.x = '0;
                sc_d.y = (sc_q.y == YW'(ROWS - 1)) ? '0 : sc_q.y + 1'b1;
            end else begin
                sc_d.x = sc_q.x + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= sc_d;
    end

    assign ptr_x     = sc_q.x;
    assign ptr_y     = sc_q.y;
    assign out_valid = sc_q.valid;
    assign out_sof   = sc_q.sof;
    assign out_data  = sc_q.data;
endmodule

// File: rtl/pixel_grid_rasterizer.sv
module pixel_grid_rasterizer
    import pgr_pkg::*;
#(
    parameter int COLS  = 16,
    parameter int ROWS  = 16,
    parameter int PIX_W = 8,
    localparam int XW   = $clog2(COLS),
    localparam int YW   = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             draw_valid,
    output logic             draw_ready,
    input  logic [XW-1:0]    draw_x0,
    input  logic [YW-1:0]    draw_y0,
    input  logic [XW-1:0]    draw_x1,
    input  logic [YW-1:0]    draw_y1,
    input  logic [PIX_W-1:0] draw_color,
    input  logic             acc_en,
    input  logic             acc_we,
    input  logic [XW-1:0]    acc_x,
    input  logic [YW-1:0]    acc_y,
    input  logic [PIX_W-1:0] acc_wdata,
    output logic [PIX_W-1:0] acc_rdata,
    input  logic             scan_en,
    output logic             scan_valid,
    output logic             scan_sof,
    output logic [PIX_W-1:0] scan_data
);
    localparam int KW = (XW > YW) ? XW : YW;

    // ---------------- segment normalisation ----------------
    logic [KW-1:0] x0e, y0e, x1e, y1e;
    logic [KW-1:0] adx, ady, s_major, s_minor, dmaj, dmin;
    logic          minor_neg;
    major_e        major;

    assign x0e = KW'(draw_x0);
    assign y0e = KW'(draw_y0);
    assign x1e = KW'(draw_x1);
    assign y1e = KW'(draw_y1);

    always_comb begin
        adx = (x1e >= x0e) ? (x1e - x0e) : (x0e - x1e);
        ady = (y1e >= y0e) ? (y1e - y0e) : (y0e - y1e);
        if (adx >= ady) begin
            major = MAJOR_X;
            dmaj  = adx;
            dmin  = ady;
            if (x0e <= x1e) begin
                s_major = x0e; s_minor = y0e; minor_neg = (y1e < y0e);
            end else begin
                s_major = x1e; s_minor = y1e; minor_neg = (y0e < y1e);
            end
        end else begin
            major = MAJOR_Y;
            dmaj  = ady;
            dmin  = adx;
            if (y0e <= y1e) begin
                s_major = y0e; s_minor = x0e; minor_neg = (x1e < x0e);
            end else begin
                s_major = y1e; s_minor = x1e; minor_neg = (x0e < x1e);
            end
        end
    end

    // ---------------- row and column calculation units ----------------
    logic [COLS-1:0][KW-1:0] col_key_c;
    logic [COLS-1:0]         col_act_c;
    logic [ROWS-1:0][KW-1:0] row_key_c;
    logic [ROWS-1:0]         row_act_c;

    for (genvar c = 0; c < COLS; c++) begin : g_col_unit
        pgr_axis_unit #(.KW(KW), .IDX(c)) u_unit (
            .is_major (major == MAJOR_X),
            .s_major  (s_major),
            .s_minor  (s_minor),
            .dmaj     (dmaj),
            .dmin     (dmin),
            .minor_neg(minor_neg),
            .key      (col_key_c[c]),
            .act      (col_act_c[c])
        );
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row_unit
        pgr_axis_unit #(.KW(KW), .IDX(r)) u_unit (
            .is_major (major == MAJOR_Y),
            .s_major  (s_major),
            .s_minor  (s_minor),
            .dmaj     (dmaj),
            .dmin     (dmin),
            .minor_neg(minor_neg),
            .key      (row_key_c[r]),
            .act      (row_act_c[r])
        );
    end

    // ---------------- stage registers ----------------
    typedef struct packed {
        logic                    pend;
        logic [PIX_W-1:0]        color;
        logic [COLS-1:0][KW-1:0] col_key;
        logic [COLS-1:0]         col_act;
        logic [ROWS-1:0][KW-1:0] row_key;
        logic [ROWS-1:0]         row_act;
        logic [PIX_W-1:0]        rdata;
    } state_t;

    state_t st_d, st_q;

    logic [PIX_W-1:0] pix [ROWS][COLS];
    logic             draw_fire;
    logic             write_now;

    assign draw_ready = !st_q.pend;
    assign draw_fire  = draw_valid && draw_ready;
    assign write_now  = st_q.pend;

    always_comb begin
        st_d      = st_q;
        st_d.pend = 1'b0;
        if (draw_fire) begin
            st_d.pend    = 1'b1;
            st_d.color   = draw_color;
            st_d.col_key = col_key_c;
            st_d.col_act = col_act_c;
            st_d.row_key = row_key_c;
            st_d.row_act = row_act_c;
        end
        if (acc_en && !acc_we) st_d.rdata = pix[acc_y][acc_x];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_rdata = st_q.rdata;

    // ---------------- pixel array ----------------
    logic [ROWS*COLS-1:0] sel_flat;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic hit, poke;
            assign hit  = st_q.pend && st_q.col_act[c] && st_q.row_act[r]
                          && (st_q.col_key[c] == st_q.row_key[r]);
            assign poke = acc_en && acc_we && (acc_x == XW'(c)) && (acc_y == YW'(r));
            assign sel_flat[r*COLS + c] = hit;
            pgr_cell #(.PIX_W(PIX_W)) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .draw_hit  (hit),
                .draw_color(st_q.color),
                .poke_hit  (poke),
                .poke_data (acc_wdata),
                .value     (pix[r][c])
            );
        end
    end

    // ---------------- raster port ----------------
    logic [XW-1:0] scan_px;
    logic [YW-1:0] scan_py;

    pgr_scan #(.COLS(COLS), .ROWS(ROWS), .PIX_W(PIX_W)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (scan_en),
        .pix_in   (pix[scan_py][scan_px]),
        .ptr_x    (scan_px),
        .ptr_y    (scan_py),
        .out_valid(scan_valid),
        .out_sof  (scan_sof),
        .out_data (scan_data)
    );
endmodule

// File: rtl/pgr_checker.sv
module pgr_checker #(
    parameter int NCELL   = 256,
    parameter int PIX_W   = 8,
    parameter int MAXSPAN = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             draw_valid,
    input logic             draw_ready,
    input logic             acc_en,
    input logic             acc_we,
    input logic [PIX_W-1:0] acc_rdata,
    input logic             scan_en,
    input logic             scan_valid,
    input logic             scan_sof,
    input logic             write_now,
    input logic [NCELL-1:0] sel_flat
);
    assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (draw_valid && draw_ready) |=> !draw_ready);

    assert_ready_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !draw_ready |=> draw_ready);

    assert_write_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        write_now |-> ($countones(sel_flat) >= 1));

    assert_write_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        write_now |-> ($countones(sel_flat) <= MAXSPAN));

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && !acc_we) |=> $stable(acc_rdata));

    assert_scan_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> scan_valid);

    assert_scan_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> !scan_valid);

    assert_sof_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        scan_sof |-> scan_valid);
endmodule

bind pixel_grid_rasterizer pgr_checker #(
    .NCELL  (ROWS * COLS),
    .PIX_W  (PIX_W),
    .MAXSPAN((COLS > ROWS) ? COLS : ROWS)
) u_pgr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .draw_valid(draw_valid),
    .draw_ready(draw_ready),
    .acc_en    (acc_en),
    .acc_we    (acc_we),
    .acc_rdata (acc_rdata),
    .scan_en   (scan_en),
    .scan_valid(scan_valid),
    .scan_sof  (scan_sof),
    .write_now (write_now),
    .sel_flat  (sel_flat)
);

// File: tb/pixel_grid_rasterizer_tb.sv
`timescale 1ns/1ps
module pixel_grid_rasterizer_tb;
    localparam int COLS  = 16;
    localparam int ROWS  = 16;
    localparam int PIX_W = 8;
    localparam int XW    = 4;
    localparam int YW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             draw_valid = 1'b0;
    logic             draw_ready;
    logic [XW-1:0]    draw_x0 = '0, draw_x1 = '0;
    logic [YW-1:0]    draw_y0 = '0, draw_y1 = '0;
    logic [PIX_W-1:0] draw_color = '0;
    logic             acc_en = 1'b0, acc_we = 1'b0;
    logic [XW-1:0]    acc_x = '0;
    logic [YW-1:0]    acc_y = '0;
    logic [PIX_W-1:0] acc_wdata = '0;
    logic [PIX_W-1:0] acc_rdata;
    logic             scan_en = 1'b0;
    logic             scan_valid, scan_sof;
    logic [PIX_W-1:0] scan_data;

    always #2.5 clk = ~clk;

    pixel_grid_rasterizer #(.COLS(COLS), .ROWS(ROWS), .PIX_W(PIX_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .draw_valid(draw_valid), .draw_ready(draw_ready),
        .draw_x0(draw_x0), .draw_y0(draw_y0), .draw_x1(draw_x1), .draw_y1(draw_y1),
        .draw_color(draw_color),
        .acc_en(acc_en), .acc_we(acc_we), .acc_x(acc_x), .acc_y(acc_y),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .scan_en(scan_en), .scan_valid(scan_valid), .scan_sof(scan_sof),
        .scan_data(scan_data)
    );

    int    checks = 0;
    int    failures = 0;
    string cur_tag = "R1";

    // reference model state
    int ref_mem [ROWS][COLS] = '{default: '{default: 0}};
    int exp_rdata = 0, exp_sdata = 0;
    bit exp_sv = 1'b0, exp_sof = 1'b0;
    int sp_x = 0, sp_y = 0;
    bit m_pend = 1'b0;
    int p_x0 = 0, p_y0 = 0, p_x1 = 0, p_y1 = 0, p_col = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural segment rule from R3/R4 (start = endpoint lower on major axis).
    task automatic ref_draw(input int ax, input int ay, input int bx, input int by, input int col);
        int adx, ady, sa, sb, eb, off;
        adx = (ax > bx) ? ax - bx : bx - ax;
        ady = (ay > by) ? ay - by : by - ay;
        if (adx >= ady) begin
            if (ax <= bx) begin sa = ax; sb = ay; eb = by; end
            else          begin sa = bx; sb = by; eb = ay; end
            for (int k = 0; k <= adx; k++) begin
                off = (adx == 0) ? 0 : (2 * ady * k + adx) / (2 * adx);
                ref_mem[(eb >= sb) ? sb + off : sb - off][sa + k] = col;
            end
        end else begin
            if (ay <= by) begin sa = ay; sb = ax; eb = bx; end
            else          begin sa = by; sb = bx; eb = ax; end
            for (int k = 0; k <= ady; k++) begin
                off = (2 * adx * k + ady) / (2 * ady);
                ref_mem[sa + k][(eb >= sb) ? sb + off : sb - off] = col;
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++) ref_mem[r][c] = 0;
            exp_rdata = 0; exp_sdata = 0; exp_sv = 0; exp_sof = 0;
            sp_x = 0; sp_y = 0; m_pend = 0;
        end else begin
            if (acc_en && !acc_we) exp_rdata = ref_mem[acc_y][acc_x];
            exp_sv  = scan_en;
            exp_sof = scan_en && sp_x == 0 && sp_y == 0;
            if (scan_en) begin
                exp_sdata = ref_mem[sp_y][sp_x];
                sp_x++;
                if (sp_x == COLS) begin
                    sp_x = 0;
                    sp_y = (sp_y == ROWS - 1) ? 0 : sp_y + 1;
                end
            end
            if (acc_en && acc_we) ref_mem[acc_y][acc_x] = int'(acc_wdata);
            if (m_pend) begin
                ref_draw(p_x0, p_y0, p_x1, p_y1, p_col);
                m_pend = 0;
            end else if (draw_valid) begin
                m_pend = 1;
                p_x0 = int'(draw_x0); p_y0 = int'(draw_y0);
                p_x1 = int'(draw_x1); p_y1 = int'(draw_y1);
                p_col = int'(draw_color);
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        chk(draw_ready == !m_pend, "R2", "draw_ready", int'(draw_ready), int'(!m_pend));
        chk(scan_valid == exp_sv, "R10", "scan_valid", int'(scan_valid), int'(exp_sv));
        chk(scan_sof == exp_sof, "R10", "scan_sof", int'(scan_sof), int'(exp_sof));
        chk(int'(scan_data) == exp_sdata, cur_tag, "scan_data", int'(scan_data), exp_sdata);
        chk(int'(acc_rdata) == exp_rdata, (cur_tag == "R1") ? "R1" : "R8", "acc_rdata",
            int'(acc_rdata), exp_rdata);
    end

    task automatic draw(input int ax, input int ay, input int bx, input int by, input int col);
        @(negedge clk);
        while (!draw_ready) @(negedge clk);
        draw_x0 = XW'(ax); draw_y0 = YW'(ay); draw_x1 = XW'(bx); draw_y1 = YW'(by);
        draw_color = PIX_W'(col);
        draw_valid = 1'b1;
        @(negedge clk);
        draw_valid = 1'b0;
    endtask

    task automatic poke(input int x, input int y, input int v);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_x = XW'(x); acc_y = YW'(y); acc_wdata = PIX_W'(v);
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic peek(input int x, input int y);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_x = XW'(x); acc_y = YW'(y);
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic scan_frame(input string tag);
        @(negedge clk);
        cur_tag = tag;
        scan_en = 1'b1;
        repeat (ROWS * COLS) @(negedge clk);
        scan_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired checks=%0d", checks);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset contents via a full raster frame
        scan_frame("R1");
        // R8: random write and read back, untouched pixel reads 0
        cur_tag = "R8";
        poke(3, 4, 8'h5a); poke(15, 15, 8'hc3); poke(0, 0, 8'h01);
        peek(3, 4); peek(15, 15); peek(0, 0); peek(9, 9);
        // R3: horizontal, diagonal, shallow slopes both signs
        draw(2, 5, 13, 5, 8'h11);  scan_frame("R3");
        draw(0, 0, 15, 15, 8'h33); scan_frame("R3");
        draw(1, 3, 14, 8, 8'h21);  scan_frame("R3");
        draw(0, 12, 15, 6, 8'h23); scan_frame("R3");
        // R4: vertical and steep both signs
        draw(7, 1, 7, 14, 8'h22);  scan_frame("R4");
        draw(3, 0, 9, 15, 8'h24);  scan_frame("R4");
        draw(12, 2, 10, 13, 8'h25); scan_frame("R4");
        // R5: reversed endpoints overwrite exactly the same pixels
        draw(14, 8, 1, 3, 8'h44);  scan_frame("R5");
        draw(9, 15, 3, 0, 8'h45);  scan_frame("R5");
        draw(15, 6, 0, 12, 8'h46); scan_frame("R5");
        // R6: degenerate segment
        draw(5, 9, 5, 9, 8'h55);   scan_frame("R6");
        // R7: background preserved around a segment
        cur_tag = "R7";
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) poke(c, r, 8'ha5);
        draw(2, 1, 12, 7, 8'h66);  scan_frame("R7");
        // R2: command held valid across a busy cycle
        cur_tag = "R2";
        @(negedge clk);
        draw_x0 = 4'd0; draw_y0 = 4'd2; draw_x1 = 4'd15; draw_y1 = 4'd2;
        draw_color = 8'h71; draw_valid = 1'b1;
        @(negedge clk);
        draw_x0 = 4'd4; draw_y0 = 4'd0; draw_x1 = 4'd6; draw_y1 = 4'd15;
        draw_color = 8'h72;
        repeat (2) @(negedge clk);
        draw_valid = 1'b0;
        repeat (2) @(negedge clk);
        scan_frame("R2");
        // R9: draw and random write on the same pixel and edge
        @(negedge clk);
        draw_x0 = 4'd0; draw_y0 = 4'd10; draw_x1 = 4'd15; draw_y1 = 4'd10;
        draw_color = 8'h77; draw_valid = 1'b1;
        @(negedge clk);
        draw_valid = 1'b0;
        acc_en = 1'b1; acc_we = 1'b1; acc_x = 4'd4; acc_y = 4'd10; acc_wdata = 8'h88;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
        cur_tag = "R9";
        peek(4, 10);
        scan_frame("R9");
        // R10: scan pauses and resumes, frame wraps
        @(negedge clk);
        cur_tag = "R10";
        scan_en = 1'b1; repeat (5) @(negedge clk);
        scan_en = 1'b0; repeat (3) @(negedge clk);
        scan_en = 1'b1; repeat (ROWS * COLS + 20) @(negedge clk);
        scan_en = 1'b0;
        // R11: writes and draws while the scan is running
        @(negedge clk);
        cur_tag = "R11";
        scan_en = 1'b1;
        poke(1, 0, 8'h99);
        draw(0, 15, 15, 0, 8'hbb);
        poke(8, 8, 8'hcc);
        repeat (2 * ROWS * COLS) @(negedge clk);
        scan_en = 1'b0;
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule